// File: doc/BRIEF.md
# Data-Path Test Plan Sequencer

This block drives the control inputs of an RTL data path while that data path tests itself at the speed of the system clock. It holds two small registers and a plan table. The first register names the combinational element under test. The second holds a stored control-input pattern for that element. The plan table gives, for every element, a fixed series of control vectors. These vectors steer test data from the primary inputs to the element and carry its response back out. They include the thru-mask enable and the register-hold enable that the test hardware adds.

Both registers load only while reset is high, taking their values from fields of the data-path primary inputs. Once reset falls they keep their values. In test mode the sequencer then steps through the selected plan, one vector per clock, and starts the plan again after its final step. At the step where test data arrives at the target's data inputs, the low field of the control vector carries the target's control-input pattern instead of the table value. For even targets the pattern comes from spare primary-input bits in that same cycle. For odd targets it comes from the stored register. With test mode low, every output is zero, so no test element is active during normal operation.

Top module: `tps_sequencer`

## Requirements
- R1: While `rst` is high, `ctrl_out` is all zero and `plan_done` is low, whatever `test_mode` is. The first cycle after reset is step 0.
- R2: On each clock with `rst` high, the target index register loads `dp_pi[1:0]` and the pattern register loads `dp_pi[11:8]`. With `rst` low both keep their values for any `dp_pi`.
- R3: The plan for target t lasts 2+t steps. In test mode the step advances by one per clock and returns to 0 after the last step.
- R4: At step s of target t, `ctrl_out[7:4]` equals (5t+3s+1) mod 16. Bit 4 is the thru-mask enable and bit 5 is the hold enable.
- R5: The justification step is step 1 for target 0 and step t for t≥1. `ctrl_out[3:0]` carries the pattern only at that step and is 0 at every other step.
- R6: For an even target the spliced pattern is `dp_pi[15:12]` of the same cycle. For an odd target it is the stored pattern register.
- R7: `plan_done` is high during exactly the cycle of a plan's last step.
- R8: With `test_mode` low, `ctrl_out` is zero (mask and hold off) and `plan_done` is low. The step is cleared, so the plan restarts at step 0 when test mode returns.
- R9: For target 0 the pattern splice and `plan_done` fall in the same cycle. After that cycle the plan wraps to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also the load enable of both registers |
| test_mode | input | 1 | High to run plans; low disables every test control |
| dp_pi | input | 16 | Data-path primary inputs: load fields and spare pattern bits |
| ctrl_out | output | 8 | Control vector to the data path |
| plan_done | output | 1 | High in the last step of a plan |

## Verification
Target 0 has a two-step plan whose justification step is also its last step. In that one cycle the pattern splice, the `plan_done` pulse and the step wrap all happen together. The bench loads target 0 and changes the spare primary-input bits on every cycle. It also toggles the register-load fields, which must be ignored after reset. Each cycle is then checked against a model: the spliced field must follow the spare bits of that same cycle, `plan_done` must be high in that cycle, and the next cycle must show the step-0 vector again.

// File: rtl/tps_pkg.sv
package tps_pkg;

    parameter int unsigned NUM_TGT    = 4;
    parameter int unsigned CV_W       = 8;
    parameter int unsigned PAT_W      = 4;
    parameter int unsigned MAX_STEPS  = 8;
    parameter int unsigned PI_W       = 16;
    parameter int unsigned PAT_LD_LSB = 8;

    localparam int unsigned TGT_W     = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
    localparam int unsigned STEP_W    = $clog2(MAX_STEPS);
    localparam int unsigned HI_W      = CV_W - PAT_W;
    localparam int unsigned SPARE_LSB = PI_W - PAT_W;

    typedef logic [TGT_W-1:0]  tgt_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [PAT_W-1:0]  pat_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [CV_W-1:0]   cv_t;

    typedef struct packed {
        hi_t  hi;
        logic just;
        logic last;
        logic spare;
    } plan_ent_t;

    function automatic int unsigned plan_len(int unsigned t);
        return 2 + t;
    endfunction

    function automatic int unsigned just_step(int unsigned t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic plan_ent_t make_entry(int unsigned t, int unsigned s);
        plan_ent_t e;
        e = '0;
        if (t >= NUM_TGT || s >= plan_len(t)) begin
            e.last = 1'b1;
        end else begin
            e.hi    = hi_t'((5 * t + 3 * s + 1) % (1 << HI_W));
            e.just  = (s == just_step(t));
            e.last  = (s == plan_len(t) - 1);
            e.spare = ((t % 2) == 0);
        end
        return e;
    endfunction

endpackage

// File: rtl/tps_load_regs.sv
module tps_load_regs
    import tps_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PI_W-1:0] dp_pi,
    output tgt_t            tgt_q,
    output pat_t            pat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= tgt_t'(dp_pi[TGT_W-1:0]);
            pat_q <= pat_t'(dp_pi[PAT_LD_LSB +: PAT_W]);
        end
    end

    // R2
    tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(tgt_q));

    // R2
    pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(pat_q));

endmodule

// File: rtl/tps_step_ctr.sv
module tps_step_ctr
    import tps_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  last,
    output step_t step_q
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            step_q <= '0;
        end else if (last) begin
            step_q <= '0;
        end else begin
            step_q <= step_q + step_t'(1);
        end
    end

    // R3
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !last) |=> (step_q == $past(step_q) + step_t'(1)));

endmodule

// File: rtl/tps_plan_rom.sv
module tps_plan_rom
    import tps_pkg::*;
(
    input  tgt_t      tgt,
    input  step_t     step,
    output plan_ent_t ent
);

    localparam int unsigned ROWS  = 1 << TGT_W;
    localparam int unsigned DEPTH = 1 << STEP_W;

    plan_ent_t plan_tbl [ROWS*DEPTH];

    for (genvar gt = 0; gt < ROWS; gt++) begin : g_tgt
        for (genvar gs = 0; gs < DEPTH; gs++) begin : g_step
            assign plan_tbl[gt*DEPTH + gs] = make_entry(gt, gs);
        end
    end

    assign ent = plan_tbl[{tgt, step}];

endmodule

// File: rtl/tps_sequencer.sv
module tps_sequencer
    import tps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  test_mode,
    input  logic [tps_pkg::PI_W-1:0] dp_pi,
    output logic [tps_pkg::CV_W-1:0] ctrl_out,
    output logic                  plan_done
);

    tgt_t      tgt_q;
    pat_t      pat_q;
    step_t     step_q;
    plan_ent_t ent;
    pat_t      splice_val;
    logic      active;

    tps_load_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .dp_pi (dp_pi),
        .tgt_q (tgt_q),
        .pat_q (pat_q)
    );

    tps_step_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .run    (test_mode),
        .last   (ent.last),
        .step_q (step_q)
    );

    tps_plan_rom u_rom (
        .tgt  (tgt_q),
        .step (step_q),
        .ent  (ent)
    );

    assign active = test_mode && !rst;

    always_comb begin
        splice_val = '0;
        if (ent.just) begin
            splice_val = ent.spare ? pat_t'(dp_pi[SPARE_LSB +: PAT_W]) : pat_q;
        end
    end

    assign ctrl_out  = active ? {ent.hi, splice_val} : '0;
    assign plan_done = active && ent.last;

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        plan_done |=> (step_q == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (ctrl_out == '0 && !plan_done));

    // R5
    splice_only_chk: assert property (@(posedge clk) disable iff (rst)
        !ent.just |-> (ctrl_out[PAT_W-1:0] == '0));

endmodule

// File: tb/tps_sequencer_tb_top.sv
module tps_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_mode = 1'b0;
    logic [15:0] dp_pi = '0;
    logic [7:0]  ctrl_out;
    logic        plan_done;

    always #2.5 clk = ~clk;

    tps_sequencer dut_i (
        .clk       (clk),
        .rst       (rst),
        .test_mode (test_mode),
        .dp_pi     (dp_pi),
        .ctrl_out  (ctrl_out),
        .plan_done (plan_done)
    );

    logic [8:0] exp_q [$];
    string      tag_q [$];
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done_flag = 1'b0;

    int m_tgt  = 0;
    int m_pat  = 0;
    int m_step = 0;

    function automatic logic [15:0] load_pi(int t, int p);
        return {4'h0, 4'(p), 6'h0, 2'(t)};
    endfunction

    task automatic cyc(input logic r, input logic m, input logic [15:0] pi, input string tag);
        logic [3:0] hi;
        logic [3:0] lo;
        logic       dn;
        int         len;
        int         jst;
        @(posedge clk);
        #1;
        rst = r;
        test_mode = m;
        dp_pi = pi;
        hi = '0; lo = '0; dn = 1'b0;
        len = 2 + m_tgt;
        jst = (m_tgt == 0) ? 1 : m_tgt;
        if (!r && m) begin
            hi = 4'((5 * m_tgt + 3 * m_step + 1) % 16);
            if (m_step == jst) lo = (m_tgt % 2 == 0) ? pi[15:12] : 4'(m_pat);
            dn = (m_step == len - 1);
        end
        exp_q.push_back({dn, hi, lo});
        tag_q.push_back(tag);
        if (r) begin
            m_tgt = int'(pi[1:0]);
            m_pat = int'(pi[11:8]);
            m_step = 0;
        end else if (!m || dn) begin
            m_step = 0;
        end else begin
            m_step = m_step + 1;
        end
    endtask

    initial begin : monitor
        logic [8:0] e;
        string      t;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({plan_done, ctrl_out} !== e) begin
                    n_fail++;
                    $display("FAIL %s: got ctrl_out=%h plan_done=%b expected ctrl_out=%h plan_done=%b",
                             t, ctrl_out, plan_done, e[7:0], e[8]);
                end
            end
        end
    end

    initial begin : watchdog
        #100000;
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // R1 R2: reset with test mode high, load target 0 / pattern 6
        cyc(1, 1, load_pi(0, 6), "R1");
        cyc(1, 1, load_pi(0, 6), "R1");
        // R9 R7 R6: target 0, spare bits change each cycle, load fields toggled (R2)
        for (int i = 0; i < 8; i++)
            cyc(0, 1, {4'(i * 3 + 1), 4'(i), 6'h0, 2'(i)}, "R9");
        // R2 R5 R6: target 1 uses stored pattern 0xA
        cyc(1, 0, load_pi(1, 10), "R2");
        for (int i = 0; i < 9; i++)
            cyc(0, 1, {4'(15 - i), 4'h3, 6'h0, 2'(i + 2)}, "R6");
        // R4 R6: target 2 takes spare bits
        cyc(1, 1, load_pi(2, 1), "R1");
        for (int i = 0; i < 10; i++)
            cyc(0, 1, {4'(i + 7), 4'hF, 6'h3F, 2'b11}, "R4");
        // R3 R8: target 3, test mode dropped mid-plan then resumed
        cyc(1, 1, load_pi(3, 12), "R2");
        cyc(0, 1, 16'h5A5A, "R3");
        cyc(0, 1, 16'hA5A5, "R3");
        cyc(0, 1, 16'hFFFF, "R3");
        cyc(0, 0, 16'hFFFF, "R8");
        cyc(0, 0, 16'h1234, "R8");
        for (int i = 0; i < 11; i++)
            cyc(0, 1, {4'(i), 12'h0F0}, "R5");
        cyc(0, 0, 16'h0, "R8");
        cyc(1, 0, 16'hFFFF, "R1");
        repeat (2) @(negedge clk);
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule